// File: doc/BRIEF.md
# Virtual Highest-Pending Threshold Detector

This block keeps a small priority code that summarises the most urgent interrupt still waiting for a virtual processor. It raises a one-cycle external-interrupt pulse when that code climbs above a threshold. The threshold is packed from three inputs: the global interrupt enable, a mask-all bit and a four-bit priority class.

The block does no work on every cycle. Two kinds of event arm it: a condition event (the enable rising, or a write to the priority register) and a pending event (a new pend, or an end-of-interrupt). The work is done at the next evaluation strobe. A pending check loads the code from the current best pending vector, unless an in-service interrupt blocks that vector. A condition check compares the stored code with the threshold. When the code is above the threshold, the block fires the pulse and empties the code. An acknowledge empties the code without firing.

Top module: `vhpi_detector`

The two arming flags form a four-state machine:
- `ST_IDLE`: nothing is armed.
- `ST_COND`: only a condition event is waiting.
- `ST_PEND`: only a pending event is waiting.
- `ST_BOTH`: both kinds are waiting.

The transitions are:
- *arm-cond*: a condition event adds the condition flag.
- *arm-pend*: a pending event adds the pending flag.
- *consume*: an evaluation strobe without acknowledge drops back to `ST_IDLE`, keeping only events that arrive in that same cycle.
- *hold*: in any other cycle the state does not change.

## Requirements
- R1: After synchronous reset, `vhpi` is 0 and `irq_pulse` is 0. No event is armed, and the enable edge detector treats the enable as having been low.
- R2: With default parameters, a vector encodes as follows: vector 2 gives 32, vector 0 gives 16, and any other vector v gives v/16 (its upper four bits). The code is 6 bits wide.
- R3: The threshold is 32·(enable==0) + 16·mask_all + class. A check fires only when the code is strictly greater than the threshold. The pulse is high for exactly the one cycle after the clock edge that samples the evaluation strobe.
- R4: Firing clears `vhpi` to 0 on the same edge that raises `irq_pulse`.
- R5: A condition event arms a condition check. A condition event is `tpr_wr`=1, or `ena`=1 in a cycle whose previous cycle had `ena`=0. An evaluation strobe performs the check and disarms it. Without an armed check, changes of `ena`, `mmi` or `mic` never fire and never alter `vhpi`.
- R6: `pend_stb` or `eoi_stb` arms a pending check, which runs once at the next evaluation strobe. Without it, changes of `best_vec` or `best_vld` have no effect at an evaluation strobe.
- R7: `ack_stb` clears `vhpi` to 0. The code stays 0 until a pending check runs after a pend or end-of-interrupt.
- R8: In a pending check, the code is left unchanged if `best_vld`=0 or `insvc_blk`=1. Otherwise the encoded vector is loaded and compared with the threshold. If it is above the threshold, the check fires, and that firing counts as the whole check.
- R9: An evaluation strobe coinciding with `ack_stb` is deferred: no pulse, `vhpi` becomes 0, and both armed events survive. Events arriving in the same cycle as a consuming strobe stay armed for the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pend_stb | input | 1 | A single or batch pend occurred |
| eoi_stb | input | 1 | End-of-interrupt occurred |
| ack_stb | input | 1 | Interrupt vector read acknowledged; clears the code |
| tpr_wr | input | 1 | Priority register written |
| ena | input | 1 | Global interrupt enable level |
| mmi | input | 1 | Mask-all bit of the priority register |
| mic | input | CLASS_W | Priority class of the priority register |
| best_vld | input | 1 | A pending vector exists |
| best_vec | input | VEC_W | Highest pending vector |
| insvc_blk | input | 1 | Pending vector is blocked by in-service priority |
| eval_stb | input | 1 | Evaluation point |
| irq_pulse | output | 1 | External-interrupt pulse, one cycle |
| vhpi | output | CLASS_W+2 | Stored highest-pending code |

## Verification
The bench builds the detector with its default widths: 8-bit vectors and a 4-bit class. This puts the fixed levels 32 and 16, the whole class range 0 to 15 and every threshold from 0 to 63 within reach of both directed and random stimulus. The directed cases cover the following:
- comparisons where the code equals the threshold, exercising the strictness edge;
- a code of 32 against the mask-all threshold of 31;
- evaluation strobes with nothing armed;
- an acknowledge colliding with an evaluation strobe.

Random traffic then mixes events and strobes in the same cycles.

// File: rtl/vhpi_pkg.sv
package vhpi_pkg;

    // Arming state: which deferred checks wait for the next evaluation strobe
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_COND = 2'b01,
        ST_PEND = 2'b10,
        ST_BOTH = 2'b11
    } arm_state_t;

endpackage

// File: rtl/vhpi_encode.sv
module vhpi_encode #(
    parameter int VEC_W   = 8,
    parameter int CLASS_W = 4,
    parameter int NMI_VEC = 2,
    parameter int EXT_VEC = 0,
    parameter int CODE_W  = CLASS_W + 2
) (
    input  logic              vld,
    input  logic [VEC_W-1:0]  vec,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] NMI_CODE = CODE_W'(1) << (CLASS_W + 1);
    localparam logic [CODE_W-1:0] EXT_CODE = CODE_W'(1) << CLASS_W;

    always_comb begin
        if (!vld) begin
            code = '0;
        end else if (vec == VEC_W'(NMI_VEC)) begin
            code = NMI_CODE;
        end else if (vec == VEC_W'(EXT_VEC)) begin
            code = EXT_CODE;
        end else begin
            code = {2'b00, vec[VEC_W-1 -: CLASS_W]};
        end
    end

endmodule

// File: rtl/vhpi_gate.sv
module vhpi_gate #(
    parameter int CLASS_W = 4,
    parameter int CODE_W  = CLASS_W + 2
) (
    input  logic               ena,
    input  logic               mmi,
    input  logic [CLASS_W-1:0] mic,
    input  logic [CODE_W-1:0]  code,
    output logic               above
);

    logic [CODE_W-1:0] thresh;

    always_comb begin
        thresh = {~ena, mmi, mic};
        above  = (code > thresh);
    end

endmodule

// File: rtl/vhpi_detector.sv
module vhpi_detector #(
    parameter int VEC_W   = 8,
    parameter int CLASS_W = 4,
    parameter int NMI_VEC = 2,
    parameter int EXT_VEC = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pend_stb,
    input  logic                 eoi_stb,
    input  logic                 ack_stb,
    input  logic                 tpr_wr,
    input  logic                 ena,
    input  logic                 mmi,
    input  logic [CLASS_W-1:0]   mic,
    input  logic                 best_vld,
    input  logic [VEC_W-1:0]     best_vec,
    input  logic                 insvc_blk,
    input  logic                 eval_stb,
    output logic                 irq_pulse,
    output logic [CLASS_W+1:0]   vhpi
);
    import vhpi_pkg::*;

    localparam int CODE_W = CLASS_W + 2;

    arm_state_t        st_q, st_d;
    logic              ena_q;
    logic [CODE_W-1:0] code_q, code_d, code_a, enc;
    logic              irq_q, irq_d;
    logic              c_arm, p_arm, c_next, p_next;
    logic              set_c, set_p, consume, load, above, fire;

    vhpi_encode #(
        .VEC_W(VEC_W), .CLASS_W(CLASS_W),
        .NMI_VEC(NMI_VEC), .EXT_VEC(EXT_VEC), .CODE_W(CODE_W)
    ) u_enc (
        .vld (best_vld),
        .vec (best_vec),
        .code(enc)
    );

    vhpi_gate #(.CLASS_W(CLASS_W), .CODE_W(CODE_W)) u_gate (
        .ena  (ena),
        .mmi  (mmi),
        .mic  (mic),
        .code (code_a),
        .above(above)
    );

    // Decode the arming state
    always_comb begin
        unique case (st_q)
            ST_IDLE: begin c_arm = 1'b0; p_arm = 1'b0; end
            ST_COND: begin c_arm = 1'b1; p_arm = 1'b0; end
            ST_PEND: begin c_arm = 1'b0; p_arm = 1'b1; end
            ST_BOTH: begin c_arm = 1'b1; p_arm = 1'b1; end
        endcase
    end

    // Events, consumption and next state
    always_comb begin
        set_c   = tpr_wr | (ena & ~ena_q);
        set_p   = pend_stb | eoi_stb;
        consume = eval_stb & ~ack_stb;
        c_next  = set_c | (c_arm & ~consume);
        p_next  = set_p | (p_arm & ~consume);
        unique case ({c_next, p_next})
            2'b00: st_d = ST_IDLE;
            2'b10: st_d = ST_COND;
            2'b01: st_d = ST_PEND;
            2'b11: st_d = ST_BOTH;
        endcase
    end

    // Pending load, threshold decision and output values
    always_comb begin
        load   = consume & p_arm & best_vld & ~insvc_blk;
        code_a = load ? enc : code_q;
        fire   = consume & (load | c_arm) & above;
        irq_d  = fire;
        if (ack_stb || fire) begin
            code_d = '0;
        end else begin
            code_d = code_a;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Output and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            irq_q  <= 1'b0;
            ena_q  <= 1'b0;
        end else begin
            code_q <= code_d;
            irq_q  <= irq_d;
            ena_q  <= ena;
        end
    end

    assign irq_pulse = irq_q;
    assign vhpi      = code_q;

endmodule

// File: rtl/vhpi_detector_chk.sv
module vhpi_detector_chk #(
    parameter int CLASS_W = 4,
    parameter int CODE_W  = CLASS_W + 2
) (
    input logic              clk,
    input logic              rst,
    input logic              eval_stb,
    input logic              ack_stb,
    input logic              irq_pulse,
    input logic [CODE_W-1:0] vhpi
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (vhpi == '0 && !irq_pulse));

    // R2: the top level stands alone
    p_code_shape_r2: assert property (@(posedge clk) disable iff (rst)
        vhpi[CODE_W-1] |-> (vhpi[CODE_W-2:0] == '0));

    p_pulse_needs_eval_r3: assert property (@(posedge clk) disable iff (rst)
        !eval_stb |=> !irq_pulse);

    p_fire_clears_r4: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (vhpi == '0));

    p_quiet_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!eval_stb && !ack_stb) |=> $stable(vhpi));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        ack_stb |=> (vhpi == '0));

    p_ack_defers_r9: assert property (@(posedge clk) disable iff (rst)
        ack_stb |=> !irq_pulse);

endmodule

bind vhpi_detector vhpi_detector_chk #(.CLASS_W(CLASS_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .eval_stb (eval_stb),
    .ack_stb  (ack_stb),
    .irq_pulse(irq_pulse),
    .vhpi     (vhpi)
);

// File: tb/vhpi_detector_tb.sv
module vhpi_detector_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pend_stb = 0, eoi_stb = 0, ack_stb = 0, tpr_wr = 0;
    logic       ena = 0, mmi = 0, best_vld = 0, insvc_blk = 0, eval_stb = 0;
    logic [3:0] mic = 0;
    logic [7:0] best_vec = 0;
    logic       irq_pulse;
    logic [5:0] vhpi;

    int n_chk = 0, n_bad = 0;
    int m_code = 0, m_irq = 0, m_c = 0, m_p = 0, m_enaq = 0;

    always #2 clk = ~clk;

    vhpi_detector u_dut (
        .clk(clk), .rst(rst), .pend_stb(pend_stb), .eoi_stb(eoi_stb),
        .ack_stb(ack_stb), .tpr_wr(tpr_wr), .ena(ena), .mmi(mmi), .mic(mic),
        .best_vld(best_vld), .best_vec(best_vec), .insvc_blk(insvc_blk),
        .eval_stb(eval_stb), .irq_pulse(irq_pulse), .vhpi(vhpi)
    );

    function automatic int encode(int v);
        if (v == 2) return 32;
        if (v == 0) return 16;
        return v / 16;
    endfunction

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_code = 0; m_irq = 0; m_c = 0; m_p = 0; m_enaq = 0;
        end else begin
            int thr, cand, newc, newp;
            bit chk_run, do_fire;
            thr = (ena ? 0 : 32) + (mmi ? 16 : 0) + int'(mic);
            newc = (tpr_wr || (ena && m_enaq == 0)) ? 1 : 0;
            newp = (pend_stb || eoi_stb) ? 1 : 0;
            m_enaq = ena ? 1 : 0;
            m_irq = 0;
            if (ack_stb) begin
                m_code = 0;
                m_c = m_c | newc;
                m_p = m_p | newp;
            end else if (eval_stb) begin
                cand = m_code;
                chk_run = (m_c != 0);
                if (m_p != 0 && best_vld && !insvc_blk) begin
                    cand = encode(int'(best_vec));
                    chk_run = 1;
                end
                do_fire = chk_run && (cand > thr);
                m_code = do_fire ? 0 : cand;
                m_irq = do_fire ? 1 : 0;
                m_c = newc;
                m_p = newp;
            end else begin
                m_c = m_c | newc;
                m_p = m_p | newp;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare against the reference on every cycle, away from the rising edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("model vhpi", int'(vhpi), m_code);
            chk("model irq", int'(irq_pulse), m_irq);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pend(int v, bit vld, bit blk);
        best_vec = 8'(v); best_vld = vld; insvc_blk = blk;
        pend_stb = 1; tick(); pend_stb = 0;
    endtask

    task automatic evaluate();
        eval_stb = 1; tick(); eval_stb = 0;
    endtask

    task automatic tpr(bit mm, int cl);
        mmi = mm; mic = 4'(cl); tpr_wr = 1; tick(); tpr_wr = 0;
    endtask

    initial begin
        tick(4);
        rst = 0;
        tick();
        chk("R1 reset vhpi", int'(vhpi), 0);
        chk("R1 reset irq", int'(irq_pulse), 0);
        best_vec = 8'h57; best_vld = 1;
        evaluate();
        chk("R1 nothing armed", int'(vhpi), 0);

        // Class encoding, then enable rise fires
        pend(8'h57, 1, 0); evaluate();
        chk("R2 class code", int'(vhpi), 5);
        chk("R8 masked load no pulse", int'(irq_pulse), 0);
        ena = 1; tick(); evaluate();
        chk("R5 enable rise fires", int'(irq_pulse), 1);
        chk("R4 fire clears", int'(vhpi), 0);
        tick();
        chk("R3 one-cycle pulse", int'(irq_pulse), 0);

        // NMI level against full masks
        ena = 0; tick();
        pend(2, 1, 0); evaluate();
        chk("R2 NMI code", int'(vhpi), 32);
        tpr(1, 15); evaluate();
        chk("R3 32 vs 63 no fire", int'(irq_pulse), 0);
        ena = 1; tick(); evaluate();
        chk("R3 NMI above mask-all", int'(irq_pulse), 1);

        // ExtINT level
        mic = 0; tick();
        pend(0, 1, 0); evaluate();
        chk("R2 ExtINT code", int'(vhpi), 16);
        chk("R3 equal no fire", int'(irq_pulse), 0);
        tpr(0, 15); evaluate();
        chk("R3 16 vs 15 fires", int'(irq_pulse), 1);

        // Strictness on the class
        tpr(0, 5); evaluate();
        pend(8'h5A, 1, 0); evaluate();
        chk("R3 5 vs 5 no fire", int'(irq_pulse), 0);
        chk("R8 loaded", int'(vhpi), 5);
        tpr(0, 4); evaluate();
        chk("R3 5 vs 4 fires", int'(irq_pulse), 1);

        // No armed check: priority changes have no effect
        tpr(1, 15); evaluate();
        pend(8'h90, 1, 0); evaluate();
        chk("R8 load 9", int'(vhpi), 9);
        mmi = 0; mic = 0; tick(); evaluate();
        chk("R5 unarmed no fire", int'(irq_pulse), 0);
        chk("R5 unarmed code kept", int'(vhpi), 9);
        tpr(0, 0); tick(3); evaluate();
        chk("R5 retained flag fires", int'(irq_pulse), 1);

        // In-service block and null vector
        tpr(1, 15); evaluate();
        pend(8'h90, 1, 0); evaluate();
        pend(8'hC0, 1, 1); evaluate();
        chk("R8 in-service keeps", int'(vhpi), 9);
        pend(8'hC0, 0, 0); evaluate();
        chk("R8 null keeps", int'(vhpi), 9);

        // Acknowledge and end-of-interrupt
        ack_stb = 1; tick(); ack_stb = 0;
        chk("R7 ack clears", int'(vhpi), 0);
        best_vec = 8'h90; best_vld = 1; evaluate();
        chk("R7 stays cleared", int'(vhpi), 0);
        eoi_stb = 1; tick(); eoi_stb = 0; evaluate();
        chk("R7 eoi reloads", int'(vhpi), 9);

        // Pending flag needed for the vector to matter
        best_vec = 8'hB0; evaluate();
        chk("R6 unarmed vector ignored", int'(vhpi), 9);
        pend(8'hB0, 1, 0); evaluate();
        chk("R6 pend loads", int'(vhpi), 11);

        // Ack colliding with evaluation
        tpr(0, 0);
        pend(8'hA0, 1, 0);
        eval_stb = 1; ack_stb = 1; tick(); eval_stb = 0; ack_stb = 0;
        chk("R9 deferred no pulse", int'(irq_pulse), 0);
        chk("R9 deferred code", int'(vhpi), 0);
        evaluate();
        chk("R9 flags kept fire", int'(irq_pulse), 1);

        // Random mix checked against the reference every cycle
        for (int i = 0; i < 3000; i++) begin
            pend_stb  = ($urandom % 5) == 0;
            eoi_stb   = ($urandom % 11) == 0;
            ack_stb   = ($urandom % 13) == 0;
            tpr_wr    = ($urandom % 6) == 0;
            eval_stb  = ($urandom % 3) == 0;
            if (($urandom % 7) == 0) ena = ~ena;
            mmi       = ($urandom % 4) == 0;
            mic       = 4'($urandom);
            best_vld  = ($urandom % 8) != 0;
            best_vec  = (($urandom % 4) == 0) ? 8'($urandom % 3) : 8'($urandom);
            insvc_blk = ($urandom % 5) == 0;
            tick();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule